// File: doc/BRIEF.md
# USB Endpoint Buffer Descriptor Engine

This block owns a small packet memory that is 16 bits wide and holds the endpoint buffers of a full-speed USB device, together with a table of buffer descriptors. The table starts at a base offset that software can program. Each endpoint has four halfwords in the table. For every endpoint the table gives a transmit buffer location, a transmit length, a receive buffer location, and a receive word. The receive word holds the allocation and the received count.

When a packet arrives, the receive side looks up the descriptor of the addressed endpoint and decodes the allocation from the block encoding. It then stores the payload bytes in pairs as halfwords. Bytes beyond the allocation are dropped and flagged. When the packet ends, the engine writes the stored byte count back into the low field of the receive word. On a transmit request the engine returns the buffer location and the length from the descriptor, for use by a serializer. A CPU reads and writes the memory one halfword at a time. It uses this port to set up descriptors and to move payload data.

Top module: `usb_bufdesc_engine`

## Requirements
- R1: After reset the table base is 0, and `rx_done`, `rx_overrun` and `tx_ack` are low.
- R2: The descriptor of endpoint n starts at byte address base + 8*n. Its four halfwords, at offsets +0, +2, +4 and +6, are the transmit address, the transmit count, the receive address and the receive word. Bit 0 of a value written to the base is ignored.
- R3: One cycle after `tx_req`, `tx_ack` is high. `tx_addr` then equals halfword +0 of the endpoint's descriptor, and `tx_len` equals bits 9:0 of halfword +2.
- R4: When bit 15 of the receive word is 0, the allocation is 2 × bits 14:10 bytes.
- R5: When bit 15 of the receive word is 1, the allocation is 32 × (bits 14:10 + 1) bytes.
- R6: Received byte k is stored at byte address rxaddr + k. Bit 0 of the receive address is ignored. The byte at an even address goes to bits 7:0 of its halfword, and the byte at an odd address goes to bits 15:8. When a packet ends on an odd byte count, the last halfword is written with 0 in bits 15:8.
- R7: Bytes that arrive after the allocation is full are discarded, and the memory past the allocation is left unchanged. `rx_overrun` pulses in the cycle after each discarded byte.
- R8: `rx_done` pulses two cycles after `rx_end`. By then, bits 9:0 of the receive word hold the number of bytes stored, and bits 15:10 keep their previous value.
- R9: A CPU write stores `cpu_wdata` at halfword `cpu_addr[AW-1:1]`. A CPU read returns that halfword on `cpu_rdata` one cycle after the request. `cpu_rdata` holds its value while no read is made.
- R10: All descriptor and buffer addresses wrap modulo MEM_BYTES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| base_we | input | 1 | Load the table base |
| base_wdata | input | AW | New table base (bit 0 ignored) |
| cpu_req | input | 1 | CPU access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | CPU byte address (bit 0 ignored) |
| cpu_wdata | input | 16 | CPU write data |
| cpu_rdata | output | 16 | CPU read data, one cycle after the request |
| rx_start | input | 1 | Start of a received packet |
| rx_ep | input | EPW | Endpoint of the received packet |
| rx_valid | input | 1 | One payload byte on `rx_byte` |
| rx_byte | input | 8 | Payload byte |
| rx_end | input | 1 | End of the received packet |
| rx_overrun | output | 1 | Pulse: a byte was discarded |
| rx_done | output | 1 | Pulse: the count has been written back |
| tx_req | input | 1 | Transmit descriptor lookup |
| tx_ep | input | EPW | Endpoint to look up |
| tx_ack | output | 1 | Lookup result valid |
| tx_addr | output | AW | Transmit buffer address |
| tx_len | output | 10 | Transmit byte count |

## Verification
The assertions check on every cycle that the stored count never exceeds the decoded allocation. They also check that overrun pulses appear only after a byte received during a packet, that `rx_done` is a single pulse that trails `rx_end` by two cycles, that `tx_ack` follows a request, and that `cpu_rdata` holds its value between reads. Only the bench's scenarios can show the block encodings being decoded to the right sizes, the byte packing with its odd-length flush, the preservation of the upper bits of the receive word, and addresses wrapping past the top of memory.

// File: rtl/usb_bufdesc_engine.sv
module usb_bufdesc_engine #(
  parameter int MEM_BYTES = 1024,
  parameter int EP_NUM    = 8,
  localparam int AW  = $clog2(MEM_BYTES),
  localparam int HW  = MEM_BYTES / 2,
  localparam int EPW = $clog2(EP_NUM)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           base_we,
  input  logic [AW-1:0]  base_wdata,
  input  logic           cpu_req,
  input  logic           cpu_we,
  input  logic [AW-1:0]  cpu_addr,
  input  logic [15:0]    cpu_wdata,
  output logic [15:0]    cpu_rdata,
  input  logic           rx_start,
  input  logic [EPW-1:0] rx_ep,
  input  logic           rx_valid,
  input  logic [7:0]     rx_byte,
  input  logic           rx_end,
  output logic           rx_overrun,
  output logic           rx_done,
  input  logic           tx_req,
  input  logic [EPW-1:0] tx_ep,
  output logic           tx_ack,
  output logic [AW-1:0]  tx_addr,
  output logic [9:0]     tx_len
);
  typedef enum logic [1:0] {S_IDLE, S_RECV, S_WB} st_t;
  st_t st;

  logic [15:0]   mem [HW];
  logic [AW-1:0] tbl_base;
  logic [AW-1:0] raddr;
  logic [10:0]   rcnt, ralloc;
  logic [7:0]    hold;
  logic [AW-2:0] rcidx;

  wire [AW-1:0] rx_desc = tbl_base + (AW'(rx_ep) << 3);
  wire [AW-1:0] tx_desc = tbl_base + (AW'(tx_ep) << 3);
  wire [AW-2:0] rxa_idx = rx_desc[AW-1:1] + (AW-1)'(2);
  wire [AW-2:0] rxc_idx = rx_desc[AW-1:1] + (AW-1)'(3);
  wire [15:0]   rxc_w   = mem[rxc_idx];
  wire [4:0]    blk     = rxc_w[14:10];
  wire [10:0]   alloc_d = rxc_w[15] ? ((11'(blk) + 11'd1) << 5) : (11'(blk) << 1);
  wire [AW-1:0] baddr   = raddr + AW'(rcnt);
  wire [AW-2:0] bidx    = baddr[AW-1:1];
  wire          room    = rcnt < ralloc;

  logic          mwe;
  logic [AW-2:0] midx;
  logic [15:0]   mwd;

  always_comb begin
    mwe = 1'b0; midx = '0; mwd = '0;
    if (st == S_RECV) begin
      if (rx_end) begin
        if (rcnt[0]) begin mwe = 1'b1; midx = bidx; mwd = {8'h00, hold}; end
      end else if (rx_valid && room && rcnt[0]) begin
        mwe = 1'b1; midx = bidx; mwd = {rx_byte, hold};
      end
    end else if (st == S_WB) begin
      mwe = 1'b1; midx = rcidx; mwd = {mem[rcidx][15:10], rcnt[9:0]};
    end
    if (!mwe && cpu_req && cpu_we) begin
      mwe = 1'b1; midx = cpu_addr[AW-1:1]; mwd = cpu_wdata;
    end
  end

  always_ff @(posedge clk) if (mwe) mem[midx] <= mwd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; tbl_base <= '0; raddr <= '0; rcnt <= '0; ralloc <= '0;
      hold <= '0; rcidx <= '0; rx_overrun <= 1'b0; rx_done <= 1'b0;
      tx_ack <= 1'b0; tx_addr <= '0; tx_len <= '0; cpu_rdata <= '0;
    end else begin
      rx_overrun <= 1'b0;
      rx_done    <= 1'b0;
      tx_ack     <= tx_req;
      if (base_we) tbl_base <= {base_wdata[AW-1:1], 1'b0};
      if (cpu_req && !cpu_we) cpu_rdata <= mem[cpu_addr[AW-1:1]];
      if (tx_req) begin
        tx_addr <= mem[tx_desc[AW-1:1]][AW-1:0];
        tx_len  <= mem[tx_desc[AW-1:1] + (AW-1)'(1)][9:0];
      end
      case (st)
        S_IDLE: if (rx_start) begin
          raddr  <= {mem[rxa_idx][AW-1:1], 1'b0};
          ralloc <= alloc_d;
          rcidx  <= rxc_idx;
          rcnt   <= '0;
          st     <= S_RECV;
        end
        S_RECV: begin
          if (rx_end) st <= S_WB;
          else if (rx_valid) begin
            if (room) begin
              if (!rcnt[0]) hold <= rx_byte;
              rcnt <= rcnt + 11'd1;
            end else rx_overrun <= 1'b1;
          end
        end
        S_WB: begin
          rx_done <= 1'b1;
          st      <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) rcnt <= ralloc);
  // R7
  ovr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |-> $past(st == S_RECV && rx_valid && !rx_end));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) rx_done |=> !rx_done);
  // R8
  done_lag_chk: assert property (@(posedge clk) disable iff (!rst_n) rx_done |-> $past(rx_end, 2));
  // R3
  tx_ack_chk: assert property (@(posedge clk) disable iff (!rst_n) tx_req |=> tx_ack);
  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cpu_req && !cpu_we) |-> $stable(cpu_rdata));
endmodule

// File: tb/tb_usb_bufdesc_engine.sv
module tb_usb_bufdesc_engine;
  localparam int AW = 10;
  localparam int EPW = 3;
  logic clk = 0, rst_n = 0;
  logic base_we = 0; logic [AW-1:0] base_wdata = '0;
  logic cpu_req = 0, cpu_we = 0; logic [AW-1:0] cpu_addr = '0; logic [15:0] cpu_wdata = '0;
  logic [15:0] cpu_rdata;
  logic rx_start = 0; logic [EPW-1:0] rx_ep = '0; logic rx_valid = 0; logic [7:0] rx_byte = '0;
  logic rx_end = 0, rx_overrun, rx_done;
  logic tx_req = 0; logic [EPW-1:0] tx_ep = '0; logic tx_ack; logic [AW-1:0] tx_addr; logic [9:0] tx_len;
  int n_cmp = 0, n_bad = 0, ovr_seen = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  usb_bufdesc_engine dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin n_bad++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic cpu_wr(input int a, input int d);
    @(negedge clk); cpu_req = 1; cpu_we = 1; cpu_addr = AW'(a); cpu_wdata = 16'(d);
    @(negedge clk); cpu_req = 0; cpu_we = 0;
  endtask

  task automatic cpu_rd_chk(input int a, input int exp, input string req);
    @(negedge clk); cpu_req = 1; cpu_we = 0; cpu_addr = AW'(a);
    @(negedge clk); cpu_req = 0;
    chk(cpu_rdata == 16'(exp), req, cpu_rdata, exp);
  endtask

  task automatic set_base(input int b);
    @(negedge clk); base_we = 1; base_wdata = AW'(b);
    @(negedge clk); base_we = 0;
  endtask

  task automatic tx_chk(input int ep, input int ea, input int el, input string req);
    @(negedge clk); tx_req = 1; tx_ep = EPW'(ep);
    @(negedge clk); tx_req = 0;
    chk(tx_ack == 1'b1, req, tx_ack, 1);
    chk(tx_addr == AW'(ea), req, tx_addr, ea);
    chk(tx_len == 10'(el), req, tx_len, el);
  endtask

  task automatic send(input int ep, input int n, input int start, input int step);
    ovr_seen = 0;
    @(negedge clk); rx_start = 1; rx_ep = EPW'(ep);
    @(negedge clk); rx_start = 0;
    for (int i = 0; i < n; i++) begin
      if (rx_overrun) ovr_seen++;
      rx_valid = 1; rx_byte = 8'(start + step * i);
      @(negedge clk);
    end
    rx_valid = 0;
    if (rx_overrun) ovr_seen++;
    rx_end = 1;
    @(negedge clk); rx_end = 0;
    chk(rx_done == 1'b0, "R8 done early", rx_done, 0);
    @(negedge clk);
    chk(rx_done == 1'b1, "R8 done timing", rx_done, 1);
  endtask

  task automatic t_reset;
    chk(rx_done == 0 && rx_overrun == 0 && tx_ack == 0, "R1 outputs", {rx_done, rx_overrun, tx_ack}, 0);
    cpu_wr(0, 16'h0123); cpu_wr(2, 16'hFC09);
    tx_chk(0, 10'h123, 9, "R1 base zero");
  endtask

  task automatic t_tx;
    set_base(16'h41);
    cpu_wr(16'h48, 16'h0100); cpu_wr(16'h4A, 16'hFC05);
    tx_chk(1, 16'h100, 5, "R2 R3 tx lookup");
  endtask

  task automatic t_small;
    cpu_wr(16'h54, 16'h0201); cpu_wr(16'h56, 16'h0D55);
    cpu_wr(16'h204, 16'hFFFF); cpu_wr(16'h206, 16'hBEEF);
    send(2, 5, 8'h11, 8'h11);
    cpu_rd_chk(16'h200, 16'h2211, "R6 pack lo/hi");
    cpu_rd_chk(16'h202, 16'h4433, "R6 pack");
    cpu_rd_chk(16'h204, 16'h0055, "R6 odd flush");
    cpu_rd_chk(16'h56, 16'h0C05, "R8 R4 count writeback");
    chk(ovr_seen == 0, "R4 no overrun", ovr_seen, 0);
  endtask

  task automatic t_small_ovr;
    send(2, 8, 8'hA0, 1);
    chk(ovr_seen == 2, "R7 overrun pulses", ovr_seen, 2);
    cpu_rd_chk(16'h204, 16'hA5A4, "R4 last in alloc");
    cpu_rd_chk(16'h206, 16'hBEEF, "R7 past alloc untouched");
    cpu_rd_chk(16'h57, 16'h0C06, "R7 R9 count capped, bit0 ignored");
  endtask

  task automatic t_large;
    cpu_wr(16'h5C, 16'h0280); cpu_wr(16'h5E, 16'h8400); cpu_wr(16'h2C0, 16'h1234);
    send(3, 70, 0, 1);
    chk(ovr_seen == 6, "R5 overrun after 64", ovr_seen, 6);
    cpu_rd_chk(16'h280, 16'h0100, "R5 first");
    cpu_rd_chk(16'h2BE, 16'h3F3E, "R5 last");
    cpu_rd_chk(16'h2C0, 16'h1234, "R7 large untouched");
    cpu_rd_chk(16'h5E, 16'h8440, "R5 R8 count");
  endtask

  task automatic t_wrap;
    set_base(16'h3F9);
    cpu_wr(16'h000, 16'h03AA); cpu_wr(16'h002, 16'h0007);
    tx_chk(1, 16'h3AA, 7, "R10 desc wrap");
    cpu_wr(16'h00C, 16'h03FE); cpu_wr(16'h00E, 16'h0800);
    send(2, 4, 8'hA1, 1);
    cpu_rd_chk(16'h3FE, 16'hA2A1, "R10 buf top");
    cpu_rd_chk(16'h000, 16'hA4A3, "R10 buf wrap");
    cpu_rd_chk(16'h00E, 16'h0804, "R10 count");
  endtask

  initial begin
    #200000;
    if (!done_flag) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_tx();
    t_small();
    t_small_ovr();
    t_large();
    t_wrap();
    done_flag = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule